// File: doc/BRIEF.md
# Reset Cause Status Register

This block keeps a record of which event brought about the most recent system reset. Each reset source arrives as an already-qualified one-cycle pulse: power-on, the external reset pin, a watchdog timeout, an illegal opcode, an opcode fetch from an illegal address, a monitor-mode entry check, and a low-voltage inhibit. The block keeps one sticky flag per source. Software reads these flags as one 8-bit read-only register on a simple peripheral bus.

A power-on event starts a fresh record. Every other source adds its own flag on top of the flags already held, so several causes can be visible at once. A read that hits the register returns the flags and also empties them, so each reset cause is reported once. The flags do not sit on the block's own synchronous reset. The cause therefore survives the system reset it describes, and only the registered read data returns to zero on that reset.

Top module: `rstcause_reg`

## Requirements
- R1: The flags appear on the read data with power-on at bit 7, external pin at bit 6, watchdog at bit 5, illegal opcode at bit 4, illegal-address fetch at bit 3, monitor entry at bit 2 and low voltage at bit 1. Bit 0 always reads 0.
- R2: A `src_por` pulse sets bit 7 and discards every flag held before it. A power-on event alone leaves the value 8'h80.
- R3: A pulse on any source other than power-on sets only its own flag. Flags already set stay set, so several flags accumulate.
- R4: A non-power-on pulse in the same cycle as a power-on pulse, or in any later cycle, keeps its flag. For example, power-on followed by low voltage reads 8'h82.
- R5: A read (`rd_en` high with `bus_addr` equal to 16'hFE01) puts the flag value on `rd_data` one clock later and clears all flags. In any cycle without a hit, `rd_data` registers 8'h00.
- R6: When a read hit and a source pulse occur in the same cycle, the read returns the value held before that cycle, and the new flag remains set afterwards.
- R7: Writes to the register address have no effect on the flags. A read at any other address returns 8'h00 and does not clear the flags.
- R8: `src_badaddr` sets bit 3 only when `fetch_op` is high in the same cycle. Otherwise it is ignored.
- R9: A `mon_chk` pulse sets bit 2 only when `vec_hi` and `vec_lo` are both 8'hFF and `irq_high` is 1.
- R10: `rst` clears `rd_data` only. Flags set before or during `rst` are still returned by the first read after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the read path |
| src_por | input | 1 | Power-on event pulse |
| src_pin | input | 1 | External reset pin event pulse |
| src_wdog | input | 1 | Watchdog timeout pulse |
| src_badop | input | 1 | Illegal opcode pulse |
| src_badaddr | input | 1 | Illegal address access pulse |
| fetch_op | input | 1 | The current access is an opcode fetch |
| mon_chk | input | 1 | Strobe for the monitor-entry vector check |
| vec_hi | input | 8 | Reset vector byte at 16'hFFFE |
| vec_lo | input | 8 | Reset vector byte at 16'hFFFF |
| irq_high | input | 1 | The IRQ pin is at the supply level |
| src_lvi | input | 1 | Low-voltage inhibit pulse |
| rd_en | input | 1 | Bus read strobe |
| wr_en | input | 1 | Bus write strobe (ignored) |
| bus_addr | input | 16 | Bus address |
| wr_data | input | 8 | Bus write data (ignored) |
| rd_data | output | 8 | Registered read data |

## Verification
The hardest case to reach is a read hit landing in the same clock as a new source pulse, where the clear and the set compete for one flag. The bench drives the read strobe and the external-pin pulse on the same falling edge. It then checks that this read returns the older watchdog flag and that a second read returns the pin flag. A power-on pulse followed one cycle later by a low-voltage pulse, with no read in between, models a slow supply ramp. The same pulse pair is also driven in a single cycle.

// File: rtl/rstcause_pkg.sv
package rstcause_pkg;
  localparam int NSRC   = 7;
  localparam int DATA_W = NSRC + 1;

  // Bit order matters: software decodes these positions.
  localparam int B_POR     = 7;
  localparam int B_PIN     = 6;
  localparam int B_WDOG    = 5;
  localparam int B_BADOP   = 4;
  localparam int B_BADADDR = 3;
  localparam int B_MON     = 2;
  localparam int B_LVI     = 1;

  // Packed so that field k lands on flag bit k+1.
  typedef struct packed {
    logic por;
    logic pin;
    logic wdog;
    logic badop;
    logic badaddr;
    logic mon;
    logic lvi;
  } src_t;
endpackage

// File: rtl/rstcause_qual.sv
module rstcause_qual
  import rstcause_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             src_por,
  input  logic             src_pin,
  input  logic             src_wdog,
  input  logic             src_badop,
  input  logic             src_badaddr,
  input  logic             fetch_op,
  input  logic             mon_chk,
  input  logic [VEC_W-1:0] vec_hi,
  input  logic [VEC_W-1:0] vec_lo,
  input  logic             irq_high,
  input  logic             src_lvi,
  output src_t             sets
);
  localparam logic [VEC_W-1:0] ERASED = '1;

  logic vec_blank;
  assign vec_blank = (vec_hi == ERASED) && (vec_lo == ERASED);

  always_comb begin
    sets.por     = src_por;
    sets.pin     = src_pin;
    sets.wdog    = src_wdog;
    sets.badop   = src_badop;
    sets.badaddr = src_badaddr && fetch_op;            // R8
    sets.mon     = mon_chk && vec_blank && irq_high;   // R9
    sets.lvi     = src_lvi;
  end
endmodule

// File: rtl/rstcause_flags.sv
module rstcause_flags
  import rstcause_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  src_t              sets,
  input  logic              clr,
  output logic [DATA_W-1:0] flags
);
  logic [NSRC-1:0] set_vec;
  logic [NSRC-1:0] held;

  assign set_vec = sets;

  // The flags are deliberately left off rst, so the cause survives it (R10).
  generate
    for (genvar b = 0; b < NSRC; b++) begin : g_flag
      if (b == NSRC - 1) begin : g_por
        always_ff @(posedge clk)
          held[b] <= set_vec[b] | (held[b] & ~clr);
      end else begin : g_other
        always_ff @(posedge clk)
          held[b] <= set_vec[b] | (held[b] & ~clr & ~sets.por);
      end
    end
  endgenerate

  assign flags = {held, 1'b0};

  // R2: power-on leaves only its own bit plus bits pulsed in that same cycle
  a_r2_por_wipes: assert property (@(posedge clk) disable iff (rst)
    sets.por |=> (flags[B_POR] && ((flags & ~{$past(set_vec), 1'b0}) == '0)));

  // R3: with no clear and no power-on, no flag falls
  a_r3_sticky: assert property (@(posedge clk) disable iff (rst)
    (!clr && !sets.por) |=> ((flags & $past(flags)) == $past(flags)));

  // R5: a clear with no concurrent source empties the register
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && set_vec == '0) |=> (flags == '0));

  // R6: a source pulsed together with a clear still shows up afterwards
  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (clr && sets.pin) |=> flags[B_PIN]);
endmodule

// File: rtl/rstcause_bus.sv
module rstcause_bus #(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] flags,
  output logic              rd_hit,
  output logic              wr_hit,
  output logic [DATA_W-1:0] rd_data
);
  logic sel;
  assign sel    = (bus_addr == BASE_ADDR);
  assign rd_hit = rd_en && sel;
  assign wr_hit = wr_en && sel;

  always_ff @(posedge clk) begin
    if (rst)         rd_data <= '0;
    else if (rd_hit) rd_data <= flags;
    else             rd_data <= '0;
  end

  // R5: a hit returns the flag value held in the hit cycle
  a_r5_read_value: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (rd_data == $past(flags)));

  // R1: the unimplemented bit never reads as 1
  a_r1_bit0_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[0] == 1'b0);

  // R7: no hit means a zero result
  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> (rd_data == '0));
endmodule

// File: rtl/rstcause_reg.sv
module rstcause_reg
  import rstcause_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              VEC_W     = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFE01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_por,
  input  logic              src_pin,
  input  logic              src_wdog,
  input  logic              src_badop,
  input  logic              src_badaddr,
  input  logic              fetch_op,
  input  logic              mon_chk,
  input  logic [VEC_W-1:0]  vec_hi,
  input  logic [VEC_W-1:0]  vec_lo,
  input  logic              irq_high,
  input  logic              src_lvi,
  input  logic              rd_en,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  src_t              sets;
  logic [DATA_W-1:0] flags;
  logic              rd_hit;
  logic              wr_hit;

  rstcause_qual #(.VEC_W(VEC_W)) u_qual (
    .src_por(src_por), .src_pin(src_pin), .src_wdog(src_wdog),
    .src_badop(src_badop), .src_badaddr(src_badaddr), .fetch_op(fetch_op),
    .mon_chk(mon_chk), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .irq_high(irq_high), .src_lvi(src_lvi), .sets(sets)
  );

  rstcause_flags u_flags (
    .clk(clk), .rst(rst), .sets(sets), .clr(rd_hit), .flags(flags)
  );

  rstcause_bus #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_bus (
    .clk(clk), .rst(rst), .rd_en(rd_en), .wr_en(wr_en), .bus_addr(bus_addr),
    .flags(flags), .rd_hit(rd_hit), .wr_hit(wr_hit), .rd_data(rd_data)
  );

  // R7: a write with any data, and no read or source, leaves the flags alone
  a_r7_write_ignored: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && (wr_data != '0) && !rd_hit && sets == '0) |=> $stable(flags));

  // R8: a data access to an illegal address never raises bit 3
  a_r8_fetch_only: assert property (@(posedge clk) disable iff (rst)
    (src_badaddr && !fetch_op && !flags[B_BADADDR] && !src_por) |=> !flags[B_BADADDR]);
endmodule

// File: tb/sim_rstcause_reg.sv
module sim_rstcause_reg;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        src_por = 0, src_pin = 0, src_wdog = 0, src_badop = 0;
  logic        src_badaddr = 0, fetch_op = 0, mon_chk = 0, irq_high = 0, src_lvi = 0;
  logic [7:0]  vec_hi = 8'h00, vec_lo = 8'h00;
  logic        rd_en = 0, wr_en = 0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  rd_data;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done = 0;

  always #5 clk = ~clk;

  rstcause_reg u0 (
    .clk(clk), .rst(rst), .src_por(src_por), .src_pin(src_pin),
    .src_wdog(src_wdog), .src_badop(src_badop), .src_badaddr(src_badaddr),
    .fetch_op(fetch_op), .mon_chk(mon_chk), .vec_hi(vec_hi), .vec_lo(vec_lo),
    .irq_high(irq_high), .src_lvi(src_lvi), .rd_en(rd_en), .wr_en(wr_en),
    .bus_addr(bus_addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  // Monitor: a read hit captured at an edge is compared at the next falling edge
  always @(posedge clk) pend <= rd_en && (bus_addr == 16'hFE01) && !rst;
  always @(negedge clk) begin
    if (pend) begin
      if (exp_q.size() == 0) check(rd_data, 8'hxx, "unexpected read");
      else check(rd_data, exp_q.pop_front(), tag_q.pop_front());
    end
  end

  task automatic idle();
    @(negedge clk);
    {src_por, src_pin, src_wdog, src_badop, src_badaddr, fetch_op, mon_chk, src_lvi} = '0;
    rd_en = 0; wr_en = 0; bus_addr = 16'h0000; wr_data = 8'h00;
  endtask

  // m order: por pin wdog badop badaddr(with fetch) mon lvi
  task automatic pulse(input logic [6:0] m);
    @(negedge clk);
    {src_por, src_pin, src_wdog, src_badop, src_badaddr, mon_chk, src_lvi} = m;
    fetch_op = m[2];
    if (m[1]) begin vec_hi = 8'hFF; vec_lo = 8'hFF; irq_high = 1; end
    idle();
  endtask

  task automatic rd(input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1; bus_addr = 16'hFE01;
    exp_q.push_back(exp); tag_q.push_back(tag);
    idle();
  endtask

  initial begin
    // reset state and power-on during rst
    @(negedge clk); src_por = 1;
    @(negedge clk); src_por = 0;
    repeat (2) @(negedge clk);
    check(rd_data, 8'h00, "R10 rd_data in reset");
    rst = 0;
    rd(8'h80, "R2 power-on value");
    rd(8'h00, "R5 clear after read");
    pulse(7'b0100000); rd(8'h40, "R3 pin only");
    pulse(7'b0010000); pulse(7'b0001000); rd(8'h30, "R3 accumulate wdog+badop");
    // R8: data access without fetch
    @(negedge clk); src_badaddr = 1; fetch_op = 0; idle();
    rd(8'h00, "R8 no fetch ignored");
    pulse(7'b0000100); rd(8'h08, "R8 fetch sets bit3");
    // R9 variants
    @(negedge clk); vec_hi = 8'hFE; vec_lo = 8'hFF; irq_high = 1; mon_chk = 1; idle();
    @(negedge clk); vec_hi = 8'hFF; vec_lo = 8'hFF; irq_high = 0; mon_chk = 1; idle();
    rd(8'h00, "R9 check fails");
    pulse(7'b0000010); rd(8'h04, "R9 monitor entry");
    pulse(7'b0000001); rd(8'h02, "R1 lvi bit1");
    // R2 wipes older flags
    pulse(7'b0100000); pulse(7'b0010000); pulse(7'b1000000); rd(8'h80, "R2 wipes older");
    pulse(7'b1000000); pulse(7'b0000001); rd(8'h82, "R4 por then lvi");
    pulse(7'b1000001); rd(8'h82, "R4 same cycle");
    // R6 simultaneous read and event
    pulse(7'b0010000);
    @(negedge clk); rd_en = 1; bus_addr = 16'hFE01; src_pin = 1;
    exp_q.push_back(8'h20); tag_q.push_back("R6 read old value"); idle();
    rd(8'h40, "R6 event survives");
    // R7 write ignored, other address read
    pulse(7'b0001000);
    @(negedge clk); wr_en = 1; bus_addr = 16'hFE01; wr_data = 8'hFF; idle();
    @(negedge clk); rd_en = 1; bus_addr = 16'hFE02; idle();
    check(rd_data, 8'h00, "R7 other address reads zero");
    rd(8'h10, "R7 write ignored and no clear");
    // R10 flags survive rst
    pulse(7'b0100000);
    @(negedge clk); rst = 1; repeat (3) @(negedge clk);
    check(rd_data, 8'h00, "R10 rd_data cleared");
    rst = 0;
    rd(8'h40, "R10 flag survives rst");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check(8'(exp_q.size()), 8'h00, "pending reads");
    done = 1;
  end

  initial begin
    fork
      begin wait (done); end
      begin repeat (5000) @(posedge clk); n_chk++; n_fail++; $display("FAIL watchdog expired"); end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule